// File: doc/BRIEF.md
# Periodic Battery Load-Test Sequencer

This block schedules and evaluates a daily load test of a backup battery. From a one-pulse-per-second tick it counts out a long interval, normally one day. When the interval expires it enables an external test load for a short window, normally one second. On the last tick of that window it samples a comparator that reports whether the battery is still above its trip point. A failing result latches a warning. The warning output is a pull-low enable for an open-drain pin: 1 pulls the pin low and 0 releases it. The block never drives the pin high.

Monitoring runs only while main power is good and the write-protect recovery delay has elapsed. Whenever that condition becomes true, a test starts at once, whether or not the warning is set. A pass on this power-up test is the only event that clears the warning. Passes on the daily tests leave the warning as it is. When power fails, any test in progress is abandoned without sampling and the schedule stops. The warning is kept through the outage, and the interval count starts again from zero at the next power-up.

Top module: `battery_test_seq`

## Requirements
- R1: After reset `load_en` is 0, `warn_pull_low` is 0, and the block waits for monitoring to become enabled. A reset clears a latched warning.
- R2: While `pwr_good` or `recov_done` is 0, ticks and comparator values have no effect. `load_en` stays 0 and the warning keeps its value.
- R3: In the clock after `pwr_good` and `recov_done` are both 1 following a period when either was 0, `load_en` rises to start the power-up test. This happens whatever the state of the warning.
- R4: A test holds `load_en` at 1 for `WINDOW_TICKS` ticks. The comparator is sampled only on the last of those ticks, and `load_en` falls in the clock after that tick.
- R5: A sample with `batt_above_trip` at 0 sets `warn_pull_low` to 1 (pin pulled low) in the clock after the sampling tick. This applies to every test.
- R6: A passing sample in a daily test leaves `warn_pull_low` unchanged.
- R7: A passing sample in the power-up test clears `warn_pull_low` to 0 (pin released).
- R8: After a test window ends, `load_en` of the next test rises after the `PERIOD_TICKS`-th tick that follows.
- R9: When `pwr_good` or `recov_done` drops, any test is abandoned without sampling in the next clock, and `load_en` returns to 0. The warning is kept, and the interval count restarts from zero at the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-clock pulse per second |
| pwr_good | input | 1 | Main supply above the power-fail level |
| recov_done | input | 1 | Write-protect recovery delay has elapsed |
| batt_above_trip | input | 1 | Comparator: battery above its trip point |
| load_en | output | 1 | Connects the battery to the test load |
| warn_pull_low | output | 1 | 1 pulls the open-drain warning pin low |

## Verification
The bench uses a short period and a two-tick window. It walks a stimulus table with several patterns. A comparator that is low early in the window and high on the last tick shows that only the final tick is sampled. A fail on a daily test followed by a daily pass shows that the latch stays set. A power cycle with the warning set followed by a pass shows the clearing path. A supply or recovery drop in the middle of a window, with the comparator low, shows that the test is abandoned without a sample. Full-interval runs after each power-up separate a counter that restarts from one that carries stale counts.

// File: rtl/battery_test_seq.sv
module battery_test_seq #(
  parameter int unsigned PERIOD_TICKS = 86400,
  parameter int unsigned WINDOW_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic pwr_good,
  input  logic recov_done,
  input  logic batt_above_trip,
  output logic load_en,
  output logic warn_pull_low
);
  localparam int PW = $clog2(PERIOD_TICKS + 1);
  localparam int WW = $clog2(WINDOW_TICKS + 1);
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_TICKS - 1);

  typedef enum logic [1:0] {ST_DOWN, ST_WAIT, ST_LOAD} st_t;

  st_t           state;
  logic [PW-1:0] per_cnt;
  logic [WW-1:0] win_cnt;
  logic          warn_q;
  logic          powerup_q;

  wire active   = pwr_good & recov_done;
  wire win_done = tick_1hz & (win_cnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_DOWN;
      per_cnt   <= '0;
      win_cnt   <= '0;
      warn_q    <= 1'b0;
      powerup_q <= 1'b0;
    end else if (!active) begin
      state     <= ST_DOWN;
      per_cnt   <= '0;
      win_cnt   <= '0;
      powerup_q <= 1'b0;
    end else begin
      case (state)
        ST_DOWN: begin
          state     <= ST_LOAD;
          win_cnt   <= '0;
          powerup_q <= 1'b1;
        end
        ST_LOAD: if (tick_1hz) begin
          if (win_done) begin
            state     <= ST_WAIT;
            per_cnt   <= '0;
            win_cnt   <= '0;
            powerup_q <= 1'b0;
            if (!batt_above_trip) warn_q <= 1'b1;
            else if (powerup_q)   warn_q <= 1'b0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_WAIT: if (tick_1hz) begin
          if (per_cnt == PER_LAST) begin
            state   <= ST_LOAD;
            per_cnt <= '0;
            win_cnt <= '0;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end
        default: state <= ST_DOWN;
      endcase
    end
  end

  assign load_en       = (state == ST_LOAD);
  assign warn_pull_low = warn_q;

  assert_powerup_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && active) |=> load_en);

  assert_load_off_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !load_en);

  assert_load_drop_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_en) |-> ($past(tick_1hz) || !$past(active)));

  assert_warn_set_by_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_pull_low) |-> $past(load_en && tick_1hz && !batt_above_trip && active));

  assert_warn_clear_by_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_pull_low) |-> $past(load_en && tick_1hz && batt_above_trip && active));
endmodule

// File: tb/battery_test_seq_bench.sv
module battery_test_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0;
  logic pwr_good = 1'b0;
  logic recov_done = 1'b0;
  logic batt_above_trip = 1'b1;
  logic load_en, warn_pull_low;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  battery_test_seq #(.PERIOD_TICKS(4), .WINDOW_TICKS(2)) u_battery_test_seq (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_good(pwr_good),
    .recov_done(recov_done), .batt_above_trip(batt_above_trip),
    .load_en(load_en), .warn_pull_low(warn_pull_low)
  );

  // {req, pwr_good, recov_done, batt_above_trip, tick, expect load_en, expect warn}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd2, 6'b101000}, {4'd2, 6'b101100},                        // R2
    {4'd3, 6'b111010},                                           // R3
    {4'd4, 6'b110110}, {4'd4, 6'b110010}, {4'd4, 6'b111100},     // R4
    {4'd8, 6'b111100}, {4'd8, 6'b111100}, {4'd8, 6'b111100}, {4'd8, 6'b111110}, // R8
    {4'd4, 6'b111110}, {4'd5, 6'b110101},                        // R4, R5
    {4'd8, 6'b111101}, {4'd8, 6'b111101}, {4'd8, 6'b111101}, {4'd8, 6'b111111},
    {4'd6, 6'b111111}, {4'd6, 6'b111101},                        // R6
    {4'd9, 6'b001101}, {4'd9, 6'b001101},                        // R9
    {4'd3, 6'b111011}, {4'd4, 6'b111111}, {4'd7, 6'b111100},     // R3, R7
    {4'd8, 6'b111100}, {4'd8, 6'b111100}, {4'd8, 6'b111100}, {4'd8, 6'b111110},
    {4'd9, 6'b010100},                                           // R9 abort mid-window
    {4'd3, 6'b110010}, {4'd4, 6'b110110}, {4'd5, 6'b110101},
    {4'd9, 6'b101101}, {4'd2, 6'b101101},
    {4'd3, 6'b111011}, {4'd4, 6'b111111}, {4'd7, 6'b111100},
    {4'd9, 6'b111100}, {4'd9, 6'b111100}, {4'd9, 6'b111100}, {4'd9, 6'b111110}
  };

  task automatic check(input int req, input logic exp_load, input logic exp_warn);
    n_checks++;
    if (load_en !== exp_load || warn_pull_low !== exp_warn) begin
      n_fails++;
      $display("FAIL R%0d: load_en=%b warn_pull_low=%b expected load_en=%b warn_pull_low=%b",
               req, load_en, warn_pull_low, exp_load, exp_warn);
    end
  endtask

  task automatic step(input logic p, input logic r, input logic b, input logic t);
    @(negedge clk);
    pwr_good = p; recov_done = r; batt_above_trip = b; tick_1hz = t;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(1, 1'b0, 1'b0); // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(int'(VEC[i][9:6]), VEC[i][1], VEC[i][0]);
    end

    // R5: power-up test failure latches the warning, then R1: reset clears it
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check(3, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check(5, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(1, 1'b0, 1'b0); // R1 warning cleared by reset

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule